// File: doc/BRIEF.md
# ADPCM Playback Expander with Starvation Hold

This block turns a stream of 4-bit adaptive differential codes into signed 16-bit PCM samples, one sample per pulse of a sample-rate tick. Codes arrive packed two to a byte from a first-word-fall-through playback FIFO that sits outside the block. The block pops a byte only when it needs a fresh one. Each code moves a predictor accumulator by a difference that scales with a step size. It then moves a step-table index up or down, so the step size follows the signal's loudness.

Two controls reset the adaptation. Dropping the playback enable clears the accumulator and the step index together. A separate one-cycle accumulator clear zeroes only the accumulator and keeps the step index. When a tick finds no code to decode, which is an underrun, the block does not change its adaptation state. It repeats the previous output sample and flags the tick. Decoding continues from the same state once bytes arrive again.

A control state machine with four states sequences the work. ST_OFF is held while playback is disabled. ST_WAIT_BYTE means no nibble is pending. ST_STALL means the last tick starved. ST_HIGH means the high nibble of the last popped byte is still to be decoded. The transitions are named as follows:
- Enable off: any state goes to ST_OFF while the enable is low.
- Wake: ST_OFF goes to ST_WAIT_BYTE when enabled with no tick.
- Fetch: ST_OFF, ST_WAIT_BYTE or ST_STALL goes to ST_HIGH on a tick with the FIFO not empty.
- Starve: ST_OFF, ST_WAIT_BYTE or ST_STALL goes to ST_STALL on a tick with the FIFO empty.
- Drain: ST_HIGH goes to ST_WAIT_BYTE on a tick.

Top module: `adpcm_play_decoder`

## Requirements
- R1: While `play_en` is low, the block clears the accumulator and the step index, drops any pending high nibble and drives `pcm_out` = 0, `pcm_valid` = 0 and `underrun` = 0. It never pops while disabled.
- R2: Each cycle with `play_en` and `sample_tick` both high gives exactly one `pcm_valid` pulse in the following cycle, and no other cycle does.
- R3: Bits [3:0] of a byte are decoded first. The byte is popped (`fifo_pop` = 1, combinationally, in the tick cycle) on the tick that decodes that low nibble. Bits [7:4] are decoded on the next tick, without a pop.
- R4: For step s and code c, the magnitude is (s>>3), plus s if c[2] is set, plus s>>1 if c[1] is set, plus s>>2 if c[0] is set. If c[3] = 1 the magnitude is subtracted from the predictor base; otherwise it is added. The result becomes the new accumulator and `pcm_out`.
- R5: The new sample is clamped to the range -32768 to 32767.
- R6: After each decoded code, the step index changes by -1 for c[2:0] in 0 to 3, +2 for 4, +4 for 5, +6 for 6 and +8 for 7. It is then clamped to 0 to 88.
- R7: The step size at index 0 is 7. Each next step is the previous step s plus (s>>3) plus 1, limited to 32767.
- R8: A tick with no nibble pending and the FIFO empty is an underrun. The block does not pop, sets `underrun` and `pcm_valid` in the next cycle, repeats the previous `pcm_out`, and leaves the accumulator and step index unchanged.
- R9: After an underrun, the next code decodes from exactly the accumulator and step index held before the underrun.
- R10: An `acc_clear` pulse zeroes the accumulator and leaves the step index unchanged. If a tick decodes a code in the same cycle, that code uses 0 as the predictor base.
- R11: `fifo_pop` is high only in a cycle with `play_en` and `sample_tick` high, `fifo_empty` low and no high nibble pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| play_en | input | 1 | Playback enable; low clears all adaptation state |
| acc_clear | input | 1 | One-cycle pulse that zeroes only the accumulator |
| sample_tick | input | 1 | One-cycle sample-rate strobe |
| fifo_empty | input | 1 | Playback FIFO holds no byte |
| fifo_byte | input | 8 | Head byte of the FIFO (fall-through) |
| fifo_pop | output | 1 | Consume the head byte this cycle |
| pcm_out | output | 16 | Signed decoded sample |
| pcm_valid | output | 1 | One-cycle pulse: a sample was produced for a tick |
| underrun | output | 1 | With `pcm_valid`: the tick found no code |

## Verification
The bench builds the block with its default parameters: 16-bit samples, an 89-entry step table and a step seed of 7. With these values the step size reaches its 32767 ceiling well below the top index. A few dozen maximum-magnitude codes of one sign therefore drive the output into both the positive and the negative clamp and push the index against 88. A long run of small codes walks the index back down to 0. The same defaults let a short randomized run mix disables, accumulator clears, starved ticks and ticks on consecutive cycles, while the FIFO occupancy stays low enough that underruns happen often.

// File: rtl/adpcm_pkg.sv
package adpcm_pkg;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_WAIT_BYTE,
        ST_STALL,
        ST_HIGH
    } play_state_e;

    // Signed change applied to the step index for a code magnitude.
    function automatic logic signed [4:0] idx_adjust(input logic [2:0] mag);
        logic signed [4:0] adj;
        unique case (mag)
            3'd4:    adj = 5'sd2;
            3'd5:    adj = 5'sd4;
            3'd6:    adj = 5'sd6;
            3'd7:    adj = 5'sd8;
            default: adj = -5'sd1;
        endcase
        return adj;
    endfunction

endpackage

// File: rtl/adpcm_step_rom.sv
module adpcm_step_rom #(
    parameter int SAMPLE_W  = 16,
    parameter int NUM_STEPS = 89,
    parameter int IDX_W     = 7,
    parameter int STEP_SEED = 7
) (
    input  logic [IDX_W-1:0]    idx,
    output logic [SAMPLE_W-1:0] step
);
    localparam int STEP_LIMIT = (1 << (SAMPLE_W - 1)) - 1;

    // Step size at position n, built from the seed by the growth rule.
    function automatic logic [SAMPLE_W-1:0] step_at(input int n);
        int s;
        s = STEP_SEED;
        for (int i = 0; i < n; i++) begin
            s = s + (s >>> 3) + 1;
            if (s > STEP_LIMIT) s = STEP_LIMIT;
        end
        return SAMPLE_W'(s);
    endfunction

    logic [SAMPLE_W-1:0] table_w [NUM_STEPS];

    generate
        for (genvar g = 0; g < NUM_STEPS; g++) begin : g_entry
            assign table_w[g] = step_at(g);
        end
    endgenerate

    assign step = (int'(idx) < NUM_STEPS) ? table_w[idx] : table_w[NUM_STEPS-1];

endmodule

// File: rtl/adpcm_nibble_expand.sv
module adpcm_nibble_expand
    import adpcm_pkg::*;
#(
    parameter int SAMPLE_W  = 16,
    parameter int NUM_STEPS = 89,
    parameter int IDX_W     = 7
) (
    input  logic [3:0]                 code,
    input  logic signed [SAMPLE_W-1:0] base,
    input  logic [SAMPLE_W-1:0]        step,
    input  logic [IDX_W-1:0]           idx,
    output logic signed [SAMPLE_W-1:0] sample_next,
    output logic [IDX_W-1:0]           idx_next
);
    localparam int SUM_W   = SAMPLE_W + 2;
    localparam int POS_LIM = (1 << (SAMPLE_W - 1)) - 1;
    localparam int NEG_LIM = -(1 << (SAMPLE_W - 1));

    logic [SAMPLE_W:0]        mag;
    logic signed [SUM_W-1:0]  sum;
    int                       idx_tmp;

    // Shift-and-add magnitude from the three low code bits.
    always_comb begin
        mag = {1'b0, step >> 3};
        if (code[2]) mag = mag + {1'b0, step};
        if (code[1]) mag = mag + {1'b0, step >> 1};
        if (code[0]) mag = mag + {1'b0, step >> 2};
    end

    // Signed update of the predictor with saturation.
    always_comb begin
        if (code[3]) sum = SUM_W'(base) - $signed({1'b0, mag});
        else         sum = SUM_W'(base) + $signed({1'b0, mag});
        if (sum > SUM_W'(POS_LIM))      sample_next = SAMPLE_W'(POS_LIM);
        else if (sum < SUM_W'(NEG_LIM)) sample_next = SAMPLE_W'(NEG_LIM);
        else                            sample_next = sum[SAMPLE_W-1:0];
    end

    // Step index adaptation with clamping to the table range.
    always_comb begin
        idx_tmp = int'(idx) + int'(idx_adjust(code[2:0]));
        if (idx_tmp < 0)                  idx_tmp = 0;
        else if (idx_tmp > NUM_STEPS - 1) idx_tmp = NUM_STEPS - 1;
        idx_next = IDX_W'(idx_tmp);
    end

endmodule

// File: rtl/adpcm_play_ctrl.sv
module adpcm_play_ctrl
    import adpcm_pkg::*;
#(
    parameter int CODE_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  play_en,
    input  logic                  sample_tick,
    input  logic                  fifo_empty,
    input  logic [2*CODE_W-1:0]   fifo_byte,
    output logic                  fifo_pop,
    output logic                  code_go,
    output logic [CODE_W-1:0]     code_val,
    output logic                  starve
);
    play_state_e        state_q, state_d;
    logic [CODE_W-1:0]  high_q, high_d;
    logic               need_byte;

    assign need_byte = (state_q != ST_HIGH);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            high_q  <= '0;
        end else begin
            state_q <= state_d;
            high_q  <= high_d;
        end
    end

    // Next state and pending-nibble capture.
    always_comb begin
        state_d = state_q;
        high_d  = high_q;
        if (!play_en) begin
            state_d = ST_OFF;
            high_d  = '0;
        end else begin
            unique case (state_q)
                ST_OFF, ST_WAIT_BYTE, ST_STALL: begin
                    if (sample_tick) begin
                        if (!fifo_empty) begin
                            state_d = ST_HIGH;
                            high_d  = fifo_byte[2*CODE_W-1:CODE_W];
                        end else begin
                            state_d = ST_STALL;
                        end
                    end else if (state_q == ST_OFF) begin
                        state_d = ST_WAIT_BYTE;
                    end
                end
                ST_HIGH: begin
                    if (sample_tick) state_d = ST_WAIT_BYTE;
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    // Outputs toward the FIFO and the predictor.
    always_comb begin
        fifo_pop = 1'b0;
        code_go  = 1'b0;
        starve   = 1'b0;
        code_val = high_q;
        if (play_en && sample_tick) begin
            if (need_byte) begin
                if (!fifo_empty) begin
                    fifo_pop = 1'b1;
                    code_go  = 1'b1;
                    code_val = fifo_byte[CODE_W-1:0];
                end else begin
                    starve = 1'b1;
                end
            end else begin
                code_go = 1'b1;
            end
        end
    end

endmodule

// File: rtl/adpcm_predictor.sv
module adpcm_predictor #(
    parameter int SAMPLE_W  = 16,
    parameter int NUM_STEPS = 89,
    parameter int IDX_W     = 7,
    parameter int STEP_SEED = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       play_en,
    input  logic                       acc_clear,
    input  logic                       code_go,
    input  logic [3:0]                 code_val,
    input  logic                       starve,
    output logic signed [SAMPLE_W-1:0] pcm_out,
    output logic                       pcm_valid,
    output logic                       underrun,
    output logic [IDX_W-1:0]           step_idx
);
    logic signed [SAMPLE_W-1:0] acc_q;
    logic signed [SAMPLE_W-1:0] base;
    logic signed [SAMPLE_W-1:0] sample_next;
    logic [SAMPLE_W-1:0]        step;
    logic [IDX_W-1:0]           idx_next;

    assign base = acc_clear ? '0 : acc_q;

    adpcm_step_rom #(
        .SAMPLE_W (SAMPLE_W),
        .NUM_STEPS(NUM_STEPS),
        .IDX_W    (IDX_W),
        .STEP_SEED(STEP_SEED)
    ) u_rom (
        .idx (step_idx),
        .step(step)
    );

    adpcm_nibble_expand #(
        .SAMPLE_W (SAMPLE_W),
        .NUM_STEPS(NUM_STEPS),
        .IDX_W    (IDX_W)
    ) u_expand (
        .code       (code_val),
        .base       (base),
        .step       (step),
        .idx        (step_idx),
        .sample_next(sample_next),
        .idx_next   (idx_next)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q     <= '0;
            step_idx  <= '0;
            pcm_out   <= '0;
            pcm_valid <= 1'b0;
            underrun  <= 1'b0;
        end else if (!play_en) begin
            acc_q     <= '0;
            step_idx  <= '0;
            pcm_out   <= '0;
            pcm_valid <= 1'b0;
            underrun  <= 1'b0;
        end else begin
            pcm_valid <= code_go | starve;
            underrun  <= starve;
            if (code_go) begin
                acc_q    <= sample_next;
                step_idx <= idx_next;
                pcm_out  <= sample_next;
            end else if (acc_clear) begin
                acc_q <= '0;
            end
        end
    end

endmodule

// File: rtl/adpcm_play_decoder.sv
module adpcm_play_decoder #(
    parameter int SAMPLE_W  = 16,
    parameter int NUM_STEPS = 89,
    parameter int STEP_SEED = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       play_en,
    input  logic                       acc_clear,
    input  logic                       sample_tick,
    input  logic                       fifo_empty,
    input  logic [7:0]                 fifo_byte,
    output logic                       fifo_pop,
    output logic signed [SAMPLE_W-1:0] pcm_out,
    output logic                       pcm_valid,
    output logic                       underrun
);
    localparam int CODE_W = 4;
    localparam int IDX_W  = $clog2(NUM_STEPS);

    logic              code_go;
    logic [CODE_W-1:0] code_val;
    logic              starve;
    logic [IDX_W-1:0]  step_idx;

    adpcm_play_ctrl #(
        .CODE_W(CODE_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .play_en    (play_en),
        .sample_tick(sample_tick),
        .fifo_empty (fifo_empty),
        .fifo_byte  (fifo_byte),
        .fifo_pop   (fifo_pop),
        .code_go    (code_go),
        .code_val   (code_val),
        .starve     (starve)
    );

    adpcm_predictor #(
        .SAMPLE_W (SAMPLE_W),
        .NUM_STEPS(NUM_STEPS),
        .IDX_W    (IDX_W),
        .STEP_SEED(STEP_SEED)
    ) u_pred (
        .clk      (clk),
        .rst_n    (rst_n),
        .play_en  (play_en),
        .acc_clear(acc_clear),
        .code_go  (code_go),
        .code_val (code_val),
        .starve   (starve),
        .pcm_out  (pcm_out),
        .pcm_valid(pcm_valid),
        .underrun (underrun),
        .step_idx (step_idx)
    );

endmodule

// File: rtl/adpcm_play_checker.sv
module adpcm_play_checker #(
    parameter int SAMPLE_W = 16,
    parameter int IDX_W    = 7
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       play_en,
    input logic                       acc_clear,
    input logic                       sample_tick,
    input logic                       fifo_empty,
    input logic                       fifo_pop,
    input logic signed [SAMPLE_W-1:0] pcm_out,
    input logic                       pcm_valid,
    input logic                       underrun,
    input logic [IDX_W-1:0]           step_idx
);
    a_r1_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !play_en |=> (pcm_out == '0 && !pcm_valid && !underrun && step_idx == '0));

    a_r2_valid_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        pcm_valid |-> $past(sample_tick && play_en));

    a_r3_no_back_to_back_pop: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |=> !fifo_pop);

    a_r8_underrun_holds_sample: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> (pcm_valid && $stable(pcm_out)));

    a_r10_clear_keeps_index: assert property (@(posedge clk) disable iff (!rst_n)
        (play_en && acc_clear && !sample_tick) |=> $stable(step_idx));

    a_r11_pop_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> (play_en && sample_tick && !fifo_empty));

endmodule

bind adpcm_play_decoder adpcm_play_checker #(
    .SAMPLE_W(SAMPLE_W),
    .IDX_W   (IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .play_en    (play_en),
    .acc_clear  (acc_clear),
    .sample_tick(sample_tick),
    .fifo_empty (fifo_empty),
    .fifo_pop   (fifo_pop),
    .pcm_out    (pcm_out),
    .pcm_valid  (pcm_valid),
    .underrun   (underrun),
    .step_idx   (step_idx)
);

// File: tb/adpcm_play_decoder_bench.sv
module adpcm_play_decoder_bench;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              play_en = 1'b0;
    logic              acc_clear = 1'b0;
    logic              sample_tick = 1'b0;
    logic              fifo_empty;
    logic [7:0]        fifo_byte;
    logic              fifo_pop;
    logic signed [15:0] pcm_out;
    logic              pcm_valid;
    logic              underrun;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] mem [1024];
    int rd = 0;
    int wr = 0;

    int  m_acc = 0;
    int  m_idx = 0;
    int  m_out = 0;
    bit  m_have = 0;
    logic [3:0] m_high = '0;

    always #5 clk = ~clk;

    assign fifo_empty = (rd == wr);
    assign fifo_byte  = mem[rd % 1024];

    adpcm_play_decoder u_adpcm_play_decoder (
        .clk        (clk),
        .rst_n      (rst_n),
        .play_en    (play_en),
        .acc_clear  (acc_clear),
        .sample_tick(sample_tick),
        .fifo_empty (fifo_empty),
        .fifo_byte  (fifo_byte),
        .fifo_pop   (fifo_pop),
        .pcm_out    (pcm_out),
        .pcm_valid  (pcm_valid),
        .underrun   (underrun)
    );

    function automatic int step_of(input int idx);
        int s = 7;
        for (int i = 0; i < idx; i++) begin
            s = s + (s >> 3) + 1;
            if (s > 32767) s = 32767;
        end
        return s;
    endfunction

    function automatic int dec_sample(input logic [3:0] c, input int base, input int idx);
        int s = step_of(idx);
        int d = s >> 3;
        int v;
        if (c[2]) d += s;
        if (c[1]) d += s >> 1;
        if (c[0]) d += s >> 2;
        v = c[3] ? base - d : base + d;
        if (v > 32767) v = 32767;
        if (v < -32768) v = -32768;
        return v;
    endfunction

    function automatic int next_idx(input int idx, input logic [3:0] c);
        int n;
        case (c[2:0])
            3'd4: n = idx + 2;
            3'd5: n = idx + 4;
            3'd6: n = idx + 6;
            3'd7: n = idx + 8;
            default: n = idx - 1;
        endcase
        if (n < 0) n = 0;
        if (n > 88) n = 88;
        return n;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b);
        mem[wr % 1024] = b;
        wr++;
    endtask

    // One clock: drive at the falling edge, check the pop before the
    // rising edge, check registered outputs at the next falling edge.
    task automatic cyc(input bit en, input bit tk, input bit clr, input string tag);
        bit exp_pop = 0, exp_valid = 0, exp_und = 0, go = 0;
        logic [3:0] code = '0;
        play_en = en; sample_tick = tk; acc_clear = clr;
        #1;
        if (!en) begin
            m_acc = 0; m_idx = 0; m_out = 0; m_have = 0;
        end else begin
            if (tk) begin
                exp_valid = 1;
                if (m_have) begin
                    code = m_high; m_have = 0; go = 1;
                end else if (rd != wr) begin
                    code = mem[rd % 1024][3:0];
                    m_high = mem[rd % 1024][7:4];
                    m_have = 1; go = 1; exp_pop = 1;
                end else begin
                    exp_und = 1;
                end
            end
            if (go) begin
                m_out = dec_sample(code, clr ? 0 : m_acc, m_idx);
                m_idx = next_idx(m_idx, code);
                m_acc = m_out;
            end else if (clr) begin
                m_acc = 0;
            end
        end
        // R11 and R3: pop only when a fresh low nibble is consumed
        check(fifo_pop === exp_pop, "R11", int'(fifo_pop), int'(exp_pop));
        @(posedge clk);
        @(negedge clk);
        if (exp_pop) rd++;
        check(pcm_valid === exp_valid, "R2", int'(pcm_valid), int'(exp_valid));
        check(underrun === exp_und, "R8", int'(underrun), int'(exp_und));
        check(int'(pcm_out) == m_out, tag, int'(pcm_out), m_out);
    endtask

    initial begin : watchdog
        #2000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(pcm_out == 0 && !pcm_valid && !underrun, "R1", int'(pcm_out), 0);
        check(fifo_pop == 0, "R1", int'(fifo_pop), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 / R4: nibble order and basic expansion
        push(8'h31); push(8'hA5); push(8'h0C);
        cyc(1, 0, 0, "R1");
        for (int i = 0; i < 6; i++) cyc(1, 1, 0, "R4");
        cyc(1, 0, 0, "R3");
        // R8: starved ticks repeat the last sample
        cyc(1, 1, 0, "R8");
        cyc(1, 0, 0, "R8");
        cyc(1, 1, 0, "R8");
        // R9: resume from the held state
        push(8'h52);
        cyc(1, 1, 0, "R9");
        cyc(1, 1, 0, "R9");
        // R10: clear alone, then clear together with a decode
        cyc(1, 0, 1, "R10");
        push(8'h60); push(8'h17);
        cyc(1, 1, 0, "R10");
        cyc(1, 1, 1, "R10");
        cyc(1, 1, 1, "R10");
        cyc(1, 1, 0, "R10");
        // R1: disable drops a pending high nibble
        push(8'h9F); push(8'h03);
        cyc(1, 1, 0, "R1");
        cyc(0, 1, 0, "R1");
        cyc(0, 0, 0, "R1");
        cyc(1, 1, 0, "R1");
        cyc(1, 1, 0, "R1");
        // R7: step table walked by +2 index codes from a clean start
        cyc(0, 0, 0, "R7");
        for (int i = 0; i < 20; i++) push(8'h44);
        for (int i = 0; i < 40; i++) cyc(1, 1, 0, "R7");
        // R5 / R6: positive then negative saturation, index ceiling
        for (int i = 0; i < 30; i++) push(8'h77);
        for (int i = 0; i < 60; i++) cyc(1, 1, 0, "R5");
        for (int i = 0; i < 30; i++) push(8'hFF);
        for (int i = 0; i < 60; i++) cyc(1, 1, 0, "R5");
        // R6: small codes walk the index down to its floor
        for (int i = 0; i < 60; i++) push(8'h21);
        for (int i = 0; i < 120; i++) cyc(1, 1, 0, "R6");
        // Random mix
        for (int i = 0; i < 4000; i++) begin
            bit en, tk, clr;
            en  = ($urandom % 100) != 0;
            tk  = ($urandom % 3) == 0;
            clr = ($urandom % 40) == 0;
            if (($urandom % 2) == 0 && (wr - rd) < 16) push(8'($urandom));
            cyc(en, tk, clr, "R4");
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule